// File: doc/BRIEF.md
# Single-Level Page Table Translator

This block turns a virtual address into a physical address by consulting a flat page table held in memory. The virtual address is split into a page number (upper bits) and a byte offset (lower bits). The page number is first compared against the table length. If it is in range, the block reads one table entry from memory and checks the entry's flag bits against the kind of access. If the checks pass, it returns the physical address built from the entry's physical page number and the offset, which is carried through unchanged.

A requester offers one translation at a time while `req_ready` is high. It supplies the address, whether the access is a write, the table's base byte address and the table length in entries. The table base and length are taken when the request is accepted, so each process can use its own table. The result comes back on a one-cycle `done` pulse that carries either a physical address or one of four fault causes. The memory side is a request pulse followed, after any number of cycles, by a one-cycle `mem_ready` strobe with the entry data.

Top module: `pgx_translator`

## Requirements
- R1: After synchronous reset, `req_ready` is 1, `done` is 0 and `mem_req` is 0.
- R2: A successful translation returns fault code 0 with `done_paddr` equal to the entry's physical page number placed above the unchanged low OFF_W (10) offset bits of the virtual address.
- R3: If the page number (virtual address bits above the offset) is greater than or equal to `pt_len`, the result is fault code 1 (bound). No memory request is made, and `done` rises two cycles after the accepting edge.
- R4: For an in-range page number, exactly one `mem_req` pulse is issued, with `mem_addr` = `pt_base` + 4 × page number.
- R5: An entry's bit 0 is valid, bit 1 is read-allowed, bit 2 is write-allowed, and bits [31:10] hold the physical page number. An entry whose valid bit is 0 gives fault code 2 for both reads and writes.
- R6: On a valid entry, a read with the read bit clear gives fault code 3, and a write with the write bit clear gives fault code 4. A write needs only the write bit.
- R7: `done` is high for exactly one cycle per accepted request, and `done_paddr` is 0 whenever the fault code is nonzero.
- R8: A request is accepted only while `req_ready` is high. Asserting `req_valid` while a translation is in flight has no effect on that translation and starts no new one.
- R9: The block waits any number of cycles for `mem_ready`. With a response L cycles after the request cycle's following cycle, `done` rises 5 + L cycles after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block is idle and will accept a request |
| req_vaddr | input | VA_W | Virtual address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| pt_base | input | MEM_AW | Byte address of the page table |
| pt_len | input | VPN_W+1 | Number of entries in the page table |
| mem_req | output | 1 | One-cycle table read request |
| mem_addr | output | MEM_AW | Byte address of the entry being read |
| mem_ready | input | 1 | Read data strobe |
| mem_rdata | input | PTE_W | Entry data returned with `mem_ready` |
| done | output | 1 | One-cycle result pulse |
| done_fault | output | 3 | 0 none, 1 bound, 2 invalid, 3 read denied, 4 write denied |
| done_paddr | output | PA_W | Physical address, 0 on a fault |

## Verification
A control state that takes a wrong branch shows up at the ports within the same translation. A bound miss that still fetches produces a `mem_req` pulse where none is due. A skipped wait delivers `done` earlier than 5 + L cycles. A stuck state never raises `done` or `req_ready` again. A wrongly captured entry or wrongly decoded flag appears as a wrong fault code or physical address on the very `done` pulse that ends the request. An entry address error is visible on `mem_addr` at the request cycle, before any result exists. A state that accepts a request while busy shows up as a second `done` pulse or a changed result.

// File: rtl/pgx_pkg.sv
package pgx_pkg;

    typedef enum logic [2:0] {
        FLT_NONE    = 3'd0,
        FLT_BOUND   = 3'd1,
        FLT_INVALID = 3'd2,
        FLT_RDENY   = 3'd3,
        FLT_WRDENY  = 3'd4
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BOUND,
        ST_FETCH,
        ST_WAIT,
        ST_CHECK,
        ST_DONE
    } state_e;

    localparam int FLAG_W = 3;

    typedef struct packed {
        logic wr_ok;
        logic rd_ok;
        logic valid;
    } pte_flags_t;

    function automatic pte_flags_t flags_of(input logic [FLAG_W-1:0] low);
        pte_flags_t f;
        f.valid = low[0];
        f.rd_ok = low[1];
        f.wr_ok = low[2];
        return f;
    endfunction

    function automatic fault_e judge(input pte_flags_t f, input logic is_write);
        if (!f.valid)
            return FLT_INVALID;
        else if (is_write && !f.wr_ok)
            return FLT_WRDENY;
        else if (!is_write && !f.rd_ok)
            return FLT_RDENY;
        else
            return FLT_NONE;
    endfunction

endpackage

// File: rtl/pgx_range.sv
module pgx_range #(
    parameter int VPN_W       = 22,
    parameter int AW          = 32,
    parameter int ENTRY_BYTES = 4
) (
    input  logic [VPN_W-1:0] vpn,
    input  logic [VPN_W:0]   len,
    input  logic [AW-1:0]    base,
    output logic             beyond,
    output logic [AW-1:0]    entry_addr
);
    localparam int SH = $clog2(ENTRY_BYTES);

    always_comb begin
        beyond     = ({1'b0, vpn} >= len);
        entry_addr = base + (AW'(vpn) << SH);
    end
endmodule

// File: rtl/pgx_perm.sv
module pgx_perm
    import pgx_pkg::*;
#(
    parameter int PTE_W = 32,
    parameter int PPN_W = 22,
    parameter int OFF_W = 10,
    parameter int PA_W  = 32
) (
    input  logic [PTE_W-1:0] pte,
    input  logic             is_write,
    input  logic [OFF_W-1:0] offset,
    output fault_e           fault,
    output logic [PA_W-1:0]  paddr
);
    logic [PPN_W-1:0] ppn;
    pte_flags_t       flags;

    always_comb begin
        ppn   = pte[PTE_W-1 -: PPN_W];
        flags = flags_of(pte[FLAG_W-1:0]);
        fault = judge(flags, is_write);
        paddr = (fault == FLT_NONE) ? {ppn, offset} : '0;
    end
endmodule

// File: rtl/pgx_ctrl.sv
module pgx_ctrl
    import pgx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   req_valid,
    input  logic   beyond,
    input  logic   mem_ready,
    output state_e state
);
    state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (req_valid) nxt = ST_BOUND;
            ST_BOUND: nxt = beyond ? ST_DONE : ST_FETCH;
            ST_FETCH: nxt = ST_WAIT;
            ST_WAIT:  if (mem_ready) nxt = ST_CHECK;
            ST_CHECK: nxt = ST_DONE;
            ST_DONE:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    // R8: a request seen while idle is taken on the next edge
    a_r8_accept_idle: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && req_valid) |=> state == ST_BOUND);

    // R3: an out-of-range page goes straight to the result
    a_r3_bound_skips_fetch: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BOUND && beyond) |=> state == ST_DONE);

    // R9: the fetch waits as long as memory is silent
    a_r9_wait_holds: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && !mem_ready) |=> state == ST_WAIT);
endmodule

// File: rtl/pgx_translator.sv
module pgx_translator
    import pgx_pkg::*;
#(
    parameter int VA_W        = 32,
    parameter int OFF_W       = 10,
    parameter int PA_W        = 32,
    parameter int PTE_W       = 32,
    parameter int MEM_AW      = 32,
    parameter int ENTRY_BYTES = 4,
    localparam int VPN_W      = VA_W - OFF_W,
    localparam int PPN_W      = PA_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              req_write,
    input  logic [MEM_AW-1:0] pt_base,
    input  logic [VPN_W:0]    pt_len,
    output logic              mem_req,
    output logic [MEM_AW-1:0] mem_addr,
    input  logic              mem_ready,
    input  logic [PTE_W-1:0]  mem_rdata,
    output logic              done,
    output logic [2:0]        done_fault,
    output logic [PA_W-1:0]   done_paddr
);
    state_e            state;
    logic [VA_W-1:0]   va_q;
    logic              wr_q;
    logic [MEM_AW-1:0] base_q;
    logic [VPN_W:0]    len_q;
    logic [PTE_W-1:0]  pte_q;
    logic [MEM_AW-1:0] eaddr_q;
    fault_e            fault_q;
    logic [PA_W-1:0]   paddr_q;

    logic              beyond;
    logic [MEM_AW-1:0] entry_addr;
    fault_e            chk_fault;
    logic [PA_W-1:0]   chk_paddr;

    pgx_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .beyond    (beyond),
        .mem_ready (mem_ready),
        .state     (state)
    );

    pgx_range #(
        .VPN_W       (VPN_W),
        .AW          (MEM_AW),
        .ENTRY_BYTES (ENTRY_BYTES)
    ) u_range (
        .vpn        (va_q[VA_W-1:OFF_W]),
        .len        (len_q),
        .base       (base_q),
        .beyond     (beyond),
        .entry_addr (entry_addr)
    );

    pgx_perm #(
        .PTE_W (PTE_W),
        .PPN_W (PPN_W),
        .OFF_W (OFF_W),
        .PA_W  (PA_W)
    ) u_perm (
        .pte      (pte_q),
        .is_write (wr_q),
        .offset   (va_q[OFF_W-1:0]),
        .fault    (chk_fault),
        .paddr    (chk_paddr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            va_q    <= '0;
            wr_q    <= 1'b0;
            base_q  <= '0;
            len_q   <= '0;
            pte_q   <= '0;
            eaddr_q <= '0;
            fault_q <= FLT_NONE;
            paddr_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    va_q   <= req_vaddr;
                    wr_q   <= req_write;
                    base_q <= pt_base;
                    len_q  <= pt_len;
                end
                ST_BOUND: begin
                    eaddr_q <= entry_addr;
                    if (beyond) begin
                        fault_q <= FLT_BOUND;
                        paddr_q <= '0;
                    end
                end
                ST_WAIT: if (mem_ready) pte_q <= mem_rdata;
                ST_CHECK: begin
                    fault_q <= chk_fault;
                    paddr_q <= chk_paddr;
                end
                default: ;
            endcase
        end
    end

    assign req_ready  = (state == ST_IDLE);
    assign mem_req    = (state == ST_FETCH);
    assign mem_addr   = eaddr_q;
    assign done       = (state == ST_DONE);
    assign done_fault = fault_q;
    assign done_paddr = paddr_q;

    // R7: result strobe lasts one cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: faulted results carry no address
    a_r7_fault_zero_addr: assert property (@(posedge clk) disable iff (rst)
        (done && done_fault != 3'd0) |-> done_paddr == '0);

    // R2: a good result keeps the requested offset
    a_r2_offset_kept: assert property (@(posedge clk) disable iff (rst)
        (done && done_fault == 3'd0) |-> done_paddr[OFF_W-1:0] == va_q[OFF_W-1:0]);

    // R4: the table read is a single-cycle pulse
    a_r4_req_single: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    // R8: no new request is offered while memory is being read
    a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !req_ready);
endmodule

// File: tb/pgx_translator_test.sv
module pgx_translator_test;
    localparam int VA_W  = 32;
    localparam int OFF_W = 10;
    localparam int VPN_W = VA_W - OFF_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [31:0]       req_vaddr = '0;
    logic              req_write = 1'b0;
    logic [31:0]       pt_base = 32'h0001_0000;
    logic [VPN_W:0]    pt_len = 23'd8;
    logic              mem_req;
    logic [31:0]       mem_addr;
    logic              mem_ready = 1'b0;
    logic [31:0]       mem_rdata = '0;
    logic              done;
    logic [2:0]        done_fault;
    logic [31:0]       done_paddr;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    pgx_translator uut (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_vaddr  (req_vaddr),
        .req_write  (req_write),
        .pt_base    (pt_base),
        .pt_len     (pt_len),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_ready  (mem_ready),
        .mem_rdata  (mem_rdata),
        .done       (done),
        .done_fault (done_fault),
        .done_paddr (done_paddr)
    );

    // Page table contents: ppn in [31:10], W R V in bits 2..0 (R5)
    function automatic logic [31:0] pte_of(input int idx);
        logic [21:0] ppn;
        logic [2:0]  fl;
        case (idx)
            0: begin ppn = 22'h000123; fl = 3'b111; end
            1: begin ppn = 22'h000456; fl = 3'b011; end
            2: begin ppn = 22'h3FFFFF; fl = 3'b101; end
            3: begin ppn = 22'h000777; fl = 3'b000; end
            4: begin ppn = 22'h000ABC; fl = 3'b001; end
            default: begin ppn = 22'(idx + 5); fl = 3'b111; end
        endcase
        return {ppn, 7'd0, fl};
    endfunction

    // Memory model: responds lat_cfg cycles after the request is seen
    int          lat_cfg = 0;
    int          pend_cnt = 0;
    logic        pending = 1'b0;
    logic [31:0] pend_addr = '0;
    int          nreq = 0;
    logic [31:0] last_addr = '0;

    always @(negedge clk) begin
        mem_ready = 1'b0;
        if (pending) begin
            if (pend_cnt == 0) begin
                mem_ready = 1'b1;
                mem_rdata = pte_of(int'((pend_addr - pt_base) >> 2));
                pending   = 1'b0;
            end else begin
                pend_cnt = pend_cnt - 1;
            end
        end
        if (mem_req) begin
            pending   = 1'b1;
            pend_cnt  = lat_cfg;
            pend_addr = mem_addr;
            nreq      = nreq + 1;
            last_addr = mem_addr;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run exceeded 20000 cycles (actual=%0d expected<=20000)", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    logic [2:0]  r_fault;
    logic [31:0] r_paddr;
    int          r_cyc;

    // Issue one request; optionally pulse req_valid again while busy
    task automatic run(input logic [31:0] va, input logic wr, input int lat,
                       input logic poke);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        nreq      = 0;
        lat_cfg   = lat;
        req_vaddr = va;
        req_write = wr;
        req_valid = 1'b1;
        r_cyc     = 0;
        forever begin
            @(negedge clk);
            r_cyc     = r_cyc + 1;
            req_valid = 1'b0;
            if (poke && r_cyc == 3) begin
                req_valid = 1'b1;
                req_vaddr = 32'h0000_2000;
                req_write = 1'b1;
            end
            if (done) break;
            if (r_cyc > 100) break;
        end
        req_valid = 1'b0;
        r_fault = done_fault;
        r_paddr = done_paddr;
        @(negedge clk);
        check("R7 done lasts one cycle", 32'(done), 32'd0);
    endtask

    typedef struct packed {
        logic [31:0] va;
        logic        wr;
        logic [3:0]  lat;
        logic [2:0]  fault;
        logic [31:0] paddr;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0155, 1'b0, 4'd0, 3'd0, 32'h0004_8D55},
        '{32'h0000_07FF, 1'b1, 4'd1, 3'd4, 32'h0},
        '{32'h0000_0400, 1'b0, 4'd2, 3'd0, 32'h0011_5800},
        '{32'h0000_0AA0, 1'b1, 4'd3, 3'd0, 32'hFFFF_FEA0},
        '{32'h0000_0810, 1'b0, 4'd0, 3'd3, 32'h0},
        '{32'h0000_0C00, 1'b0, 4'd4, 3'd2, 32'h0},
        '{32'h0000_0C3C, 1'b1, 4'd1, 3'd2, 32'h0},
        '{32'h0000_1005, 1'b1, 4'd2, 3'd4, 32'h0},
        '{32'h0000_1005, 1'b0, 4'd0, 3'd3, 32'h0},
        '{32'h0000_1FFF, 1'b0, 4'd5, 3'd0, 32'h0000_33FF},
        '{32'h0000_2000, 1'b0, 4'd0, 3'd1, 32'h0},
        '{32'hFFFF_FFFF, 1'b1, 4'd0, 3'd1, 32'h0},
        '{32'h0000_1800, 1'b1, 4'd0, 3'd0, 32'h0000_2C00}
    };

    function automatic string tag_for(input logic [2:0] f);
        case (f)
            3'd0: return "R2 translated address";
            3'd1: return "R3 bound fault";
            3'd2: return "R5 invalid fault";
            default: return "R6 permission fault";
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 req_ready after reset", 32'(req_ready), 32'd1);
        check("R1 done after reset", 32'(done), 32'd0);
        check("R1 mem_req after reset", 32'(mem_req), 32'd0);

        for (int i = 0; i < NV; i++) begin
            vec_t v = VECS[i];
            int   vpn = int'(v.va >> OFF_W);
            run(v.va, v.wr, int'(v.lat), 1'b0);
            check(tag_for(v.fault), 32'(r_fault), 32'(v.fault));
            check("R7 paddr on result", r_paddr, v.paddr);
            if (v.fault == 3'd1) begin
                check("R3 no memory request on bound", 32'(nreq), 32'd0);
                check("R3 bound latency", 32'(r_cyc), 32'd2);
            end else begin
                check("R4 one memory request", 32'(nreq), 32'd1);
                check("R4 entry address", last_addr, pt_base + 32'(vpn) * 32'd4);
                check("R9 latency 5+L", 32'(r_cyc), 32'(5 + int'(v.lat)));
            end
        end

        // R8: req_valid while busy is ignored
        run(32'h0000_0155, 1'b0, 3, 1'b1);
        check("R8 busy request ignored (fault)", 32'(r_fault), 32'd0);
        check("R8 busy request ignored (paddr)", r_paddr, 32'h0004_8D55);
        check("R8 single fetch", 32'(nreq), 32'd1);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R8 no second done", 32'(done), 32'd0);
            check("R8 stays ready", 32'(req_ready), 32'd1);
        end

        // R3: zero-length table rejects page 0
        pt_len = '0;
        run(32'h0000_0000, 1'b0, 0, 1'b0);
        check("R3 empty table bound", 32'(r_fault), 32'd1);
        check("R3 empty table no fetch", 32'(nreq), 32'd0);

        // R4: other base address, page 1
        pt_len  = 23'd8;
        pt_base = 32'h2000_0040;
        run(32'h0000_0523, 1'b0, 2, 1'b0);
        check("R4 relocated entry address", last_addr, 32'h2000_0044);
        check("R2 relocated translation", r_paddr, 32'h0011_5923);

        // R1: reset in the middle of a fetch returns to idle
        @(negedge clk);
        req_vaddr = 32'h0000_0000;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 idle after mid-run reset", 32'(req_ready), 32'd1);
        check("R1 no done after mid-run reset", 32'(done), 32'd0);
        repeat (8) @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule